// File: doc/BRIEF.md
# Partitioned SIMD Integer ALU with Predication

This unit executes packed integer operations on a 128-bit datapath. One lane-size select splits each operand into 16 lanes of 8 bits, 8 of 16, 4 of 32 or 2 of 64. The lanes are processed independently, and no carry or borrow crosses a lane boundary. The lane operations are add and subtract (wrapping or saturating), minimum, maximum, absolute difference and population count. A compare writes one predicate bit per lane. A reduction adds all lanes of the first operand into one scalar.

The second operand is either a vector or a scalar. A scalar is broadcast to every lane from its low lane-width bits. A per-lane mask qualifies every operation. Lane-wise results use merge semantics: a lane whose mask bit is clear takes its value from the prior-destination input. One sign select controls both the saturation bounds and the compare ordering.

The result and the predicate are registered, with one cycle of latency. A valid strobe accompanies the inputs, and the unit raises a matching valid on its outputs in the next cycle. The outputs hold when no operation is issued.

Top module: `simd_alu`

## Requirements
- R1: `out_valid` equals `in_valid` of the previous cycle, and `result`/`pred` reflect the operation issued in that cycle. When `in_valid` is 0, `result` and `pred` keep their values.
- R2: The `lsize` encoding is 0 = 16x8, 1 = 8x16, 2 = 4x32 and 3 = 2x64. Lane i occupies bits [i*W +: W], and mask/pred bit i belongs to lane i. Opcode 0 (ADD) and opcode 1 (SUB) wrap modulo 2^W within each lane, with no carry across lanes. Predicate bits at or above the lane count are 0.
- R3: Opcode 2 (ADDS) and opcode 3 (SUBS) clamp to the lane limits on overflow. With `is_signed` = 1 the limits are [-2^(W-1), 2^(W-1)-1]. With `is_signed` = 0 the limits are [0, 2^W-1].
- R4: Opcode 4 (MIN) and opcode 5 (MAX) order the lanes signed when `is_signed` = 1 and unsigned otherwise. Opcode 6 (ABSD) gives |a-b| as a W-bit unsigned value.
- R5: Opcode 7 (POPC) writes the number of set bits of each lane of `src_a`, zero-extended to W bits.
- R6: With `use_scalar` = 1, `scalar[W-1:0]` replaces every lane of the second operand.
- R7: For opcodes 0 to 7, a lane whose mask bit is 0 takes its value from the same lane of `old_dst`.
- R8: Opcodes 8 (EQ), 9 (NE) and 10 (LT, ordered by `is_signed`) leave `result` equal to `old_dst`. They set `pred[i]` = mask[i] AND compare(lane i). All other opcodes drive `pred` to 0.
- R9: Opcode 11 (RSUM) adds the unsigned lanes of `src_a` whose mask bit is 1. The sum is zero-extended into the full 128-bit `result`, so every lane above lane 0 is cleared.
- R10: After reset, `out_valid`, `result` and `pred` are 0.
- R11: Opcodes 12 to 15 leave `result` equal to `old_dst` and `pred` equal to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Operation issue strobe |
| opcode | input | 4 | Operation select |
| lsize | input | 2 | Lane size select |
| is_signed | input | 1 | Signed ordering and saturation |
| use_scalar | input | 1 | Broadcast scalar as second operand |
| src_a | input | 128 | First vector operand |
| src_b | input | 128 | Second vector operand |
| scalar | input | 64 | Scalar operand |
| old_dst | input | 128 | Prior destination value for merging |
| mask | input | 16 | Per-lane enable |
| out_valid | output | 1 | Result valid |
| result | output | 128 | Registered result vector |
| pred | output | 16 | Registered predicate bits |

## Verification
The registered result is the only state in the unit, so any internal fault shows at the ports in the cycle after the operation that exposes it. A lane decode or carry-isolation fault corrupts a neighbouring lane. A wrong mask index leaks data into a masked lane or loses an active one. A wrong saturation bound or ordering gives a wrong lane value. A fault in the hold path changes `result` during idle cycles. Each of these appears on `result` or `pred` exactly one cycle after issue.

// File: rtl/simd_alu_pkg.sv
package simd_alu_pkg;
    localparam int unsigned VEC_W     = 128;
    localparam int unsigned SCAL_W    = 64;
    localparam int unsigned MIN_LANE  = 8;
    localparam int unsigned N_SIZES   = 4;
    localparam int unsigned LANES_MAX = VEC_W / MIN_LANE;

    localparam logic [3:0] OP_ADD  = 4'd0;
    localparam logic [3:0] OP_SUB  = 4'd1;
    localparam logic [3:0] OP_ADDS = 4'd2;
    localparam logic [3:0] OP_SUBS = 4'd3;
    localparam logic [3:0] OP_MIN  = 4'd4;
    localparam logic [3:0] OP_MAX  = 4'd5;
    localparam logic [3:0] OP_ABSD = 4'd6;
    localparam logic [3:0] OP_POPC = 4'd7;
    localparam logic [3:0] OP_CEQ  = 4'd8;
    localparam logic [3:0] OP_CNE  = 4'd9;
    localparam logic [3:0] OP_CLT  = 4'd10;
    localparam logic [3:0] OP_RSUM = 4'd11;
endpackage

// File: rtl/simd_lane.sv
module simd_lane #(
    parameter int unsigned W = 8
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  logic [3:0]   op,
    input  logic         sgn,
    output logic [W-1:0] res,
    output logic         flag
);
    import simd_alu_pkg::*;

    logic [W:0]   ax_d, bx_d, sum_d, dif_d;
    logic [W-1:0] hi_d, lo_d, cnt_d;
    logic         lt_d, eq_d, sovf_d, dovf_d;

    always_comb begin
        ax_d   = {sgn & a[W-1], a};
        bx_d   = {sgn & b[W-1], b};
        sum_d  = ax_d + bx_d;
        dif_d  = ax_d - bx_d;
        // exact (W+1)-bit difference: its sign gives a<b in both orderings
        lt_d   = dif_d[W];
        eq_d   = (a == b);
        hi_d   = sgn ? {1'b0, {(W-1){1'b1}}} : {W{1'b1}};
        lo_d   = sgn ? {1'b1, {(W-1){1'b0}}} : {W{1'b0}};
        sovf_d = sgn ? (sum_d[W] != sum_d[W-1]) : sum_d[W];
        dovf_d = sgn ? (dif_d[W] != dif_d[W-1]) : dif_d[W];
        cnt_d  = '0;
        for (int k = 0; k < int'(W); k++) begin
            cnt_d = cnt_d + W'(a[k]);
        end

        res = sum_d[W-1:0];
        case (op)
            OP_ADD:  res = sum_d[W-1:0];
            OP_SUB:  res = dif_d[W-1:0];
            OP_ADDS: res = !sovf_d ? sum_d[W-1:0] : ((sgn && sum_d[W]) ? lo_d : hi_d);
            OP_SUBS: res = !dovf_d ? dif_d[W-1:0] : (dif_d[W] ? lo_d : hi_d);
            OP_MIN:  res = lt_d ? a : b;
            OP_MAX:  res = lt_d ? b : a;
            OP_ABSD: res = lt_d ? (W'(0) - dif_d[W-1:0]) : dif_d[W-1:0];
            OP_POPC: res = cnt_d;
            default: res = sum_d[W-1:0];
        endcase

        case (op)
            OP_CEQ:  flag = eq_d;
            OP_CNE:  flag = !eq_d;
            OP_CLT:  flag = lt_d;
            default: flag = 1'b0;
        endcase
    end
endmodule

// File: rtl/simd_lane_array.sv
module simd_lane_array #(
    parameter int unsigned VEC_W  = 128,
    parameter int unsigned SCAL_W = 64,
    parameter int unsigned LANE_W = 8,
    localparam int unsigned N     = VEC_W / LANE_W
) (
    input  logic [VEC_W-1:0]  a,
    input  logic [VEC_W-1:0]  b,
    input  logic [SCAL_W-1:0] scalar,
    input  logic              use_scalar,
    input  logic [3:0]        op,
    input  logic              sgn,
    output logic [VEC_W-1:0]  res,
    output logic [N-1:0]      flags
);
    for (genvar i = 0; i < int'(N); i++) begin : g_lane
        logic [LANE_W-1:0] b_lane;
        assign b_lane = use_scalar ? scalar[LANE_W-1:0] : b[i*LANE_W +: LANE_W];
        simd_lane #(.W(LANE_W)) u_lane (
            .a    (a[i*LANE_W +: LANE_W]),
            .b    (b_lane),
            .op   (op),
            .sgn  (sgn),
            .res  (res[i*LANE_W +: LANE_W]),
            .flag (flags[i])
        );
    end
endmodule

// File: rtl/simd_reduce.sv
module simd_reduce #(
    parameter int unsigned VEC_W    = 128,
    parameter int unsigned MIN_LANE = 8,
    parameter int unsigned N_SIZES  = 4,
    localparam int unsigned LANES_MAX = VEC_W / MIN_LANE,
    localparam int unsigned SZ_W      = $clog2(N_SIZES)
) (
    input  logic [VEC_W-1:0]     a,
    input  logic [LANES_MAX-1:0] mask,
    input  logic [SZ_W-1:0]      lsize,
    output logic [VEC_W-1:0]     sum
);
    logic [VEC_W-1:0] part [N_SIZES];

    for (genvar g = 0; g < int'(N_SIZES); g++) begin : g_size
        localparam int unsigned W = MIN_LANE << g;
        localparam int unsigned N = VEC_W / W;
        always_comb begin
            part[g] = '0;
            for (int i = 0; i < int'(N); i++) begin
                if (mask[i]) begin
                    part[g] = part[g] + VEC_W'(a[i*W +: W]);
                end
            end
        end
    end

    assign sum = part[lsize];
endmodule

// File: rtl/simd_alu.sv
module simd_alu
    import simd_alu_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 in_valid,
    input  logic [3:0]           opcode,
    input  logic [1:0]           lsize,
    input  logic                 is_signed,
    input  logic                 use_scalar,
    input  logic [VEC_W-1:0]     src_a,
    input  logic [VEC_W-1:0]     src_b,
    input  logic [SCAL_W-1:0]    scalar,
    input  logic [VEC_W-1:0]     old_dst,
    input  logic [LANES_MAX-1:0] mask,
    output logic                 out_valid,
    output logic [VEC_W-1:0]     result,
    output logic [LANES_MAX-1:0] pred
);
    localparam int unsigned BYTES = VEC_W / 8;

    typedef struct packed {
        logic                 vld;
        logic [VEC_W-1:0]     res;
        logic [LANES_MAX-1:0] pred;
    } state_t;

    state_t st_d, st_q;

    logic [VEC_W-1:0]     arr_res  [N_SIZES];
    logic [LANES_MAX-1:0] flag_pad [N_SIZES];
    logic [VEC_W-1:0]     red_sum;
    logic [VEC_W-1:0]     lane_res_d;
    logic [LANES_MAX-1:0] lane_fl_d;
    logic [BYTES-1:0]     byte_en_d;

    for (genvar g = 0; g < int'(N_SIZES); g++) begin : g_part
        localparam int unsigned LW = MIN_LANE << g;
        localparam int unsigned LN = VEC_W / LW;
        logic [LN-1:0] fl;
        simd_lane_array #(
            .VEC_W  (VEC_W),
            .SCAL_W (SCAL_W),
            .LANE_W (LW)
        ) u_arr (
            .a          (src_a),
            .b          (src_b),
            .scalar     (scalar),
            .use_scalar (use_scalar),
            .op         (opcode),
            .sgn        (is_signed),
            .res        (arr_res[g]),
            .flags      (fl)
        );
        assign flag_pad[g] = LANES_MAX'(fl);
    end

    simd_reduce #(
        .VEC_W    (VEC_W),
        .MIN_LANE (MIN_LANE),
        .N_SIZES  (N_SIZES)
    ) u_red (
        .a     (src_a),
        .mask  (mask),
        .lsize (lsize),
        .sum   (red_sum)
    );

    always_comb begin
        st_d       = st_q;
        st_d.vld   = in_valid;
        lane_res_d = arr_res[lsize];
        lane_fl_d  = flag_pad[lsize];
        for (int j = 0; j < int'(BYTES); j++) begin
            byte_en_d[j] = mask[j >> lsize];
        end
        if (in_valid) begin
            st_d.pred = '0;
            st_d.res  = old_dst;
            case (opcode)
                OP_ADD, OP_SUB, OP_ADDS, OP_SUBS,
                OP_MIN, OP_MAX, OP_ABSD, OP_POPC: begin
                    for (int j = 0; j < int'(BYTES); j++) begin
                        st_d.res[j*8 +: 8] = byte_en_d[j] ? lane_res_d[j*8 +: 8]
                                                          : old_dst[j*8 +: 8];
                    end
                end
                OP_CEQ, OP_CNE, OP_CLT: begin
                    st_d.pred = lane_fl_d & mask;
                end
                OP_RSUM: begin
                    st_d.res = red_sum;
                end
                default: begin
                    st_d.res = old_dst;
                end
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign out_valid = st_q.vld;
    assign result    = st_q.res;
    assign pred      = st_q.pred;
endmodule

// File: rtl/simd_alu_chk.sv
module simd_alu_chk (
    input logic         clk,
    input logic         rst_n,
    input logic         in_valid,
    input logic [3:0]   opcode,
    input logic [1:0]   lsize,
    input logic [15:0]  mask,
    input logic [127:0] old_dst,
    input logic         out_valid,
    input logic [127:0] result,
    input logic [15:0]  pred
);
    logic is_cmp;
    assign is_cmp = (opcode == 4'd8) || (opcode == 4'd9) || (opcode == 4'd10);

    assert_issue_R1: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);

    assert_hold_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> (!out_valid && $stable(result) && $stable(pred)));

    assert_lane_count_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && lsize == 2'd3) |=> (pred[15:2] == 14'd0));

    assert_merge_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && mask == 16'd0 && opcode != 4'd11) |=> (result == $past(old_dst)));

    assert_cmp_keep_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && is_cmp) |=> (result == $past(old_dst)));

    assert_pred_masked_R8: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> ((pred & ~$past(mask)) == 16'd0));

    assert_pred_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !is_cmp) |=> (pred == 16'd0));

    assert_sum_width_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && opcode == 4'd11 && lsize == 2'd0) |=> (result[127:12] == 116'd0));
endmodule

bind simd_alu simd_alu_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .opcode    (opcode),
    .lsize     (lsize),
    .mask      (mask),
    .old_dst   (old_dst),
    .out_valid (out_valid),
    .result    (result),
    .pred      (pred)
);

// File: tb/simd_alu_bench.sv
`timescale 1ns/1ps
module simd_alu_bench;
    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         in_valid = 1'b0;
    logic [3:0]   opcode = '0;
    logic [1:0]   lsize = '0;
    logic         is_signed = 1'b0;
    logic         use_scalar = 1'b0;
    logic [127:0] src_a = '0, src_b = '0, old_dst = '0;
    logic [63:0]  scalar = '0;
    logic [15:0]  mask = '0;
    logic         out_valid;
    logic [127:0] result;
    logic [15:0]  pred;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    always #4 clk = ~clk;

    simd_alu u_simd_alu (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .opcode(opcode),
        .lsize(lsize), .is_signed(is_signed), .use_scalar(use_scalar),
        .src_a(src_a), .src_b(src_b), .scalar(scalar), .old_dst(old_dst),
        .mask(mask), .out_valid(out_valid), .result(result), .pred(pred)
    );

    function automatic logic signed [66:0] ext(input logic [63:0] v, input int w, input bit sg);
        logic signed [66:0] e;
        e = $signed({3'b000, v});
        if (sg && v[w-1]) e = e - (67'sd1 <<< w);
        return e;
    endfunction

    task automatic model(input logic [3:0] op, input logic [1:0] sz, input bit sg, input bit us,
                         input logic [127:0] a, input logic [127:0] b, input logic [127:0] od,
                         input logic [63:0] sc, input logic [15:0] m,
                         output logic [127:0] r, output logic [15:0] p);
        int w, n;
        logic [63:0] wm, la, lb, rl;
        logic [127:0] sum;
        logic signed [66:0] ea, eb, x, hi, lo;
        bit fl;
        w = 8 << sz;
        n = 16 >> sz;
        wm = (w == 64) ? 64'hFFFF_FFFF_FFFF_FFFF : ((64'd1 << w) - 64'd1);
        r = od;
        p = '0;
        if (op == 4'd11) begin
            sum = '0;
            for (int i = 0; i < n; i++) begin
                la = 64'(a >> (i * w)) & wm;
                if (m[i]) sum = sum + {64'd0, la};
            end
            r = sum;
        end else if (op < 4'd11) begin
            hi = sg ? ((67'sd1 <<< (w - 1)) - 67'sd1) : ((67'sd1 <<< w) - 67'sd1);
            lo = sg ? -(67'sd1 <<< (w - 1)) : 67'sd0;
            for (int i = 0; i < n; i++) begin
                la = 64'(a >> (i * w)) & wm;
                lb = us ? (sc & wm) : (64'(b >> (i * w)) & wm);
                ea = ext(la, w, sg);
                eb = ext(lb, w, sg);
                fl = 1'b0;
                case (op)
                    4'd0: x = ea + eb;
                    4'd1: x = ea - eb;
                    4'd2: begin x = ea + eb; if (x > hi) x = hi; if (x < lo) x = lo; end
                    4'd3: begin x = ea - eb; if (x > hi) x = hi; if (x < lo) x = lo; end
                    4'd4: x = (ea < eb) ? ea : eb;
                    4'd5: x = (ea < eb) ? eb : ea;
                    4'd6: x = (ea > eb) ? (ea - eb) : (eb - ea);
                    4'd7: x = 67'($countones(la));
                    4'd8: begin x = 0; fl = (ea == eb); end
                    4'd9: begin x = 0; fl = (ea != eb); end
                    default: begin x = 0; fl = (ea < eb); end
                endcase
                rl = x[63:0] & wm;
                if (op < 4'd8 && m[i])
                    r = (r & ~({64'd0, wm} << (i * w))) | ({64'd0, rl} << (i * w));
                if (op >= 4'd8 && m[i] && fl) p[i] = 1'b1;
            end
        end
    endtask

    task automatic check(input string tag, input logic [127:0] er, input logic [15:0] ep);
        n_checks++;
        if (result !== er || pred !== ep || out_valid !== 1'b1) begin
            n_fail++;
            $display("FAIL %s: result=%h pred=%h vld=%b expected result=%h pred=%h vld=1",
                     tag, result, pred, out_valid, er, ep);
        end
    endtask

    // called at a negedge; returns at the next negedge after checking
    task automatic run(input string tag, input logic [3:0] op, input logic [1:0] sz,
                       input bit sg, input bit us, input logic [127:0] a, input logic [127:0] b,
                       input logic [127:0] od, input logic [63:0] sc, input logic [15:0] m);
        logic [127:0] er;
        logic [15:0]  ep;
        in_valid = 1'b1; opcode = op; lsize = sz; is_signed = sg; use_scalar = us;
        src_a = a; src_b = b; old_dst = od; scalar = sc; mask = m;
        model(op, sz, sg, us, a, b, od, sc, m, er, ep);
        @(negedge clk);
        check(tag, er, ep);
    endtask

    function automatic string tag_of(input logic [3:0] op);
        case (op)
            4'd0, 4'd1: return "R2";
            4'd2, 4'd3: return "R3";
            4'd4, 4'd5, 4'd6: return "R4";
            4'd7: return "R5";
            4'd8, 4'd9, 4'd10: return "R8";
            4'd11: return "R9";
            default: return "R11";
        endcase
    endfunction

    task automatic finish_up();
        if (!done) begin
            done = 1'b1;
            $display("  End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    endtask

    initial begin
        #(200000 * 8);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: result=timeout expected=completion");
        finish_up();
    end

    initial begin
        logic [127:0] hold_r;
        logic [15:0]  hold_p;
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        // R10: reset state
        n_checks++;
        if (out_valid !== 1'b0 || result !== '0 || pred !== '0) begin
            n_fail++;
            $display("FAIL R10: vld=%b result=%h pred=%h expected 0/0/0", out_valid, result, pred);
        end
        rst_n = 1'b1;
        @(negedge clk);

        // R2: no carry across 8-bit lanes; 64-bit lane isolation
        run("R2", 4'd0, 2'd0, 1'b0, 1'b0, {16{8'hFF}}, {16{8'h01}}, '1, '0, 16'hFFFF);
        run("R2", 4'd0, 2'd3, 1'b0, 1'b0, {64'd5, 64'hFFFF_FFFF_FFFF_FFFF},
            {64'd0, 64'd1}, '0, '0, 16'h0003);
        run("R2", 4'd1, 2'd1, 1'b0, 1'b0, '0, {8{16'h0001}}, '0, '0, 16'h00FF);
        // R3: saturation bounds
        run("R3", 4'd2, 2'd0, 1'b1, 1'b0, {16{8'h7F}}, {16{8'h01}}, '0, '0, 16'hFFFF);
        run("R3", 4'd2, 2'd0, 1'b0, 1'b0, {16{8'hFF}}, {16{8'h01}}, '0, '0, 16'hFFFF);
        run("R3", 4'd3, 2'd2, 1'b0, 1'b0, '0, {4{32'd1}}, '1, '0, 16'h000F);
        run("R3", 4'd3, 2'd1, 1'b1, 1'b0, {8{16'h8000}}, {8{16'h0001}}, '0, '0, 16'h00FF);
        // R4: signed vs unsigned ordering, absolute difference
        run("R4", 4'd4, 2'd0, 1'b1, 1'b0, {16{8'h80}}, {16{8'h01}}, '0, '0, 16'hFFFF);
        run("R4", 4'd4, 2'd0, 1'b0, 1'b0, {16{8'h80}}, {16{8'h01}}, '0, '0, 16'hFFFF);
        run("R4", 4'd6, 2'd0, 1'b1, 1'b0, {16{8'h80}}, {16{8'h7F}}, '0, '0, 16'hFFFF);
        // R5: popcount of full 64-bit lanes
        run("R5", 4'd7, 2'd3, 1'b0, 1'b0, {64'hFFFF_FFFF_FFFF_FFFF, 64'h0F}, '0, '0, '0, 16'h0003);
        // R6: scalar broadcast
        run("R6", 4'd0, 2'd1, 1'b0, 1'b1, {8{16'h1000}}, '1, '0, 64'hDEAD_BEEF_0000_0234, 16'h00FF);
        // R7: masked lanes keep old destination
        run("R7", 4'd0, 2'd0, 1'b0, 1'b0, '1, '1, {16{8'hA5}}, '0, 16'h5A5A);
        run("R7", 4'd5, 2'd2, 1'b0, 1'b0, '1, '0, {4{32'h1234_5678}}, '0, 16'h0000);
        // R8: compares, predicate limited to lane count and mask
        run("R8", 4'd8, 2'd3, 1'b0, 1'b0, {2{64'd9}}, {2{64'd9}}, {2{64'hCC}}, '0, 16'hFFFF);
        run("R8", 4'd10, 2'd0, 1'b1, 1'b0, {16{8'hF0}}, {16{8'h01}}, '0, '0, 16'h00FF);
        // R9: reduction
        run("R9", 4'd11, 2'd0, 1'b0, 1'b0, {16{8'hFF}}, '0, '1, '0, 16'hFFFF);
        run("R9", 4'd11, 2'd3, 1'b0, 1'b0, {2{64'hFFFF_FFFF_FFFF_FFFF}}, '0, '1, '0, 16'h0003);
        // R11: undefined opcode
        run("R11", 4'd15, 2'd0, 1'b0, 1'b0, '1, '1, {8{16'hBEEF}}, '0, 16'hFFFF);

        // R1: hold when no operation is issued
        hold_r = result;
        hold_p = pred;
        in_valid = 1'b0; opcode = 4'd0; src_a = '1; old_dst = '0; mask = '1;
        @(negedge clk);
        n_checks++;
        if (out_valid !== 1'b0 || result !== hold_r || pred !== hold_p) begin
            n_fail++;
            $display("FAIL R1: vld=%b result=%h pred=%h expected vld=0 result=%h pred=%h",
                     out_valid, result, pred, hold_r, hold_p);
        end

        // random mix
        for (int t = 0; t < 600; t++) begin
            logic [3:0] op;
            op = 4'($urandom_range(0, 15));
            run(tag_of(op), op, 2'($urandom_range(0, 3)), 1'($urandom), 1'($urandom_range(0, 3) == 0),
                {$urandom, $urandom, $urandom, $urandom}, {$urandom, $urandom, $urandom, $urandom},
                {$urandom, $urandom, $urandom, $urandom}, {$urandom, $urandom},
                16'($urandom));
        end
        finish_up();
    end
endmodule